// File: doc/BRIEF.md
# Packet Buffer Byte Port

This block lets a host reach a set of on-chip packet frames, each 2048 bytes deep, one byte at a time. The host sees three register targets through a small select field. Two of them are the low and high bytes of a 16-bit pointer register. The third is a data window four bytes wide. Every data access works out a byte address inside the frame named by the request's packet number. That address comes from one of two sources. If the autoincrement flag is set, the address is the pointer field itself, and the field then steps forward by one. If the flag is clear, the address is the pointer field plus the low two bits of the window offset, and the pointer is left alone. Both sums wrap inside one frame.

Requests arrive on a valid/ready channel. Read results leave on a valid/ready response channel, and a write produces no response. The block holds at most one read result. While that result sits unaccepted, `req_ready` is low, so a stalled consumer holds up the request side. A host that issues 16-bit or 32-bit accesses splits them into byte requests in ascending offset order before they reach this block.

Top module: `pktbuf_port`

## Requirements
- R1: After reset, the pointer register reads as 0x0000 and no response is pending.
- R2: A write with select 0 changes only pointer bits 7:0, and a write with select 1 changes only bits 15:8. A read with either select returns that byte.
- R3: When pointer bit 14 is set, a data access (select 2) to a valid packet uses pointer bits 10:0 as the address. Afterwards bits 10:0 have increased by one and bits 15:11 are unchanged.
- R4: With bit 14 set and pointer bits 10:0 at 2047, a data access targets byte 2047 and leaves bits 10:0 at 0.
- R5: When bit 14 is clear, a data access targets (bits 10:0 + offset) mod 2048, and the pointer register does not change.
- R6: With bit 14 clear, pointer bits 10:0 at 2047 and a nonzero offset k, the access reaches byte k-1 at the bottom of the frame without error.
- R7: A data write whose packet number is not below NUM_FRAMES writes no frame and leaves the pointer unchanged.
- R8: A data read whose packet number is not below NUM_FRAMES returns 0x00 and leaves the pointer unchanged.
- R9: Each frame is separate storage, so a write to one packet never alters the bytes of another.
- R10: `req_ready` equals `!rsp_valid || rsp_ready`. Each accepted read raises `rsp_valid` on the next cycle. `rsp_valid` and `rsp_data` hold steady while `rsp_ready` is low. An accepted write raises no response.
- R11: Select 3 is unused. A write to it changes nothing, and a read from it returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | 0 pointer low, 1 pointer high, 2 data window, 3 unused |
| req_off | input | 2 | Byte offset inside the data window |
| req_pkt | input | PKT_W | Packet (frame) number |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | 8 | Read result byte |

## Verification
Both frames are first filled through autoincrement writes. This shows that the walking pointer reaches every byte and that the two frames stay apart. Directed sequences then load pointer values at the very top of the frame, with the flag bits set and clear. These separate wrap-on-increment from wrap-on-offset, and show whether the upper flag bits survive a step. Invalid packet numbers and the unused select are mixed in, so that ignored accesses are told apart from accesses that silently move the pointer. A long random phase toggles `rsp_ready`, which separates correct back-pressure and result holding from lost or duplicated responses.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;
  localparam int PTR_REG_W = 16;
  localparam int FRAME_AW  = 11;
  localparam int FRAME_BYTES = 1 << FRAME_AW;
  localparam int AUTO_BIT  = 14;

  typedef enum logic [1:0] {
    SEL_PTR_LO = 2'd0,
    SEL_PTR_HI = 2'd1,
    SEL_DATA   = 2'd2,
    SEL_NONE   = 2'd3
  } sel_e;
endpackage

// File: rtl/pktbuf_ptr.sv
module pktbuf_ptr
  import pktbuf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_lo,
  input  logic                 wr_hi,
  input  logic [7:0]           wdata,
  input  logic                 data_acc,
  input  logic [1:0]           off,
  output logic [PTR_REG_W-1:0] ptr_q,
  output logic [FRAME_AW-1:0]  addr
);
  logic                autoinc;
  logic [FRAME_AW-1:0] base;

  always_comb begin
    autoinc = ptr_q[AUTO_BIT];
    base    = ptr_q[FRAME_AW-1:0];
    // natural FRAME_AW-bit arithmetic gives the modulo-frame wrap
    if (autoinc) addr = base;
    else         addr = base + {{(FRAME_AW-2){1'b0}}, off};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (wr_lo) begin
      ptr_q[7:0] <= wdata;
    end else if (wr_hi) begin
      ptr_q[15:8] <= wdata;
    end else if (data_acc && autoinc) begin
      ptr_q[FRAME_AW-1:0] <= base + {{(FRAME_AW-1){1'b0}}, 1'b1};
    end
  end
endmodule

// File: rtl/pktbuf_frame_ram.sv
module pktbuf_frame_ram #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/pktbuf_port.sv
module pktbuf_port
  import pktbuf_pkg::*;
#(
  parameter int NUM_FRAMES = 2,
  parameter int PKT_W      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [1:0]       req_sel,
  input  logic [1:0]       req_off,
  input  logic [PKT_W-1:0] req_pkt,
  input  logic [7:0]       req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [7:0]       rsp_data
);
  localparam logic [PKT_W:0] NF = (PKT_W+1)'(NUM_FRAMES);

  logic                 acc, pkt_ok, data_ok, wr_lo, wr_hi;
  logic [PTR_REG_W-1:0] ptr_q;
  logic [FRAME_AW-1:0]  addr;
  logic [7:0]           ram_rdata [NUM_FRAMES];
  logic [7:0]           ram_mux;
  logic                 rsp_valid_q, rsp_from_ram_q;
  logic [PKT_W-1:0]     rsp_pkt_q;
  logic [7:0]           rsp_byte_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign pkt_ok    = {1'b0, req_pkt} < NF;
  assign data_ok   = acc && (req_sel == SEL_DATA) && pkt_ok;
  assign wr_lo     = acc && req_write && (req_sel == SEL_PTR_LO);
  assign wr_hi     = acc && req_write && (req_sel == SEL_PTR_HI);

  pktbuf_ptr u_ptr (
    .clk      (clk),
    .rst      (rst),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .wdata    (req_wdata),
    .data_acc (data_ok),
    .off      (req_off),
    .ptr_q    (ptr_q),
    .addr     (addr)
  );

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    logic hit;
    assign hit = data_ok && (req_pkt == PKT_W'(g));
    pktbuf_frame_ram #(.AW(FRAME_AW)) u_ram (
      .clk   (clk),
      .we    (hit && req_write),
      .re    (hit && !req_write),
      .addr  (addr),
      .wdata (req_wdata),
      .rdata (ram_rdata[g])
    );
  end

  always_comb begin
    ram_mux = '0;
    for (int f = 0; f < NUM_FRAMES; f++) begin
      if (rsp_pkt_q == PKT_W'(f)) ram_mux = ram_rdata[f];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q    <= 1'b0;
      rsp_from_ram_q <= 1'b0;
      rsp_pkt_q      <= '0;
      rsp_byte_q     <= '0;
    end else if (acc && !req_write) begin
      rsp_valid_q    <= 1'b1;
      rsp_from_ram_q <= data_ok;
      rsp_pkt_q      <= req_pkt;
      unique case (req_sel)
        SEL_PTR_LO: rsp_byte_q <= ptr_q[7:0];
        SEL_PTR_HI: rsp_byte_q <= ptr_q[15:8];
        default:    rsp_byte_q <= 8'h00;
      endcase
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_from_ram_q ? ram_mux : rsp_byte_q;
endmodule

// File: rtl/pktbuf_port_chk.sv
module pktbuf_port_chk #(
  parameter int NUM_FRAMES = 2,
  parameter int PKT_W      = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [1:0]       req_sel,
  input logic [PKT_W-1:0] req_pkt,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [7:0]       rsp_data,
  input logic [15:0]      ptr
);
  localparam logic [PKT_W:0] NF = (PKT_W+1)'(NUM_FRAMES);
  logic rd_acc, dat_acc, bad_pkt;
  assign rd_acc  = req_valid && req_ready && !req_write;
  assign dat_acc = req_valid && req_ready && (req_sel == 2'd2);
  assign bad_pkt = !({1'b0, req_pkt} < NF);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (ptr == 16'h0000 && !rsp_valid));

  p_autoinc_step_r3: assert property (@(posedge clk) disable iff (rst)
    (dat_acc && !bad_pkt && ptr[14]) |=>
      (ptr[10:0] == $past(ptr[10:0]) + 11'd1) && (ptr[15:11] == $past(ptr[15:11])));

  p_ptr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (dat_acc && !bad_pkt && !ptr[14]) |=> $stable(ptr));

  p_bad_pkt_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (dat_acc && bad_pkt) |=> $stable(ptr));

  p_rsp_follows_read_r10: assert property (@(posedge clk) disable iff (rst)
    rd_acc |=> rsp_valid);

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_no_spurious_rsp_r10: assert property (@(posedge clk) disable iff (rst)
    (!rd_acc && !(rsp_valid && !rsp_ready)) |=> !rsp_valid);
endmodule

bind pktbuf_port pktbuf_port_chk #(.NUM_FRAMES(NUM_FRAMES), .PKT_W(PKT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_sel   (req_sel),
  .req_pkt   (req_pkt),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .ptr       (ptr_q)
);

// File: tb/test_pktbuf_port.sv
`timescale 1ns/1ps
module test_pktbuf_port;
  localparam int NF = 2;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]    req_sel = 2'd0, req_off = 2'd0;
  logic [PW-1:0] req_pkt = '0;
  logic [7:0]    req_wdata = 8'h00;
  logic          rsp_ready = 1'b1;
  logic          req_ready, rsp_valid;
  logic [7:0]    rsp_data;

  int n_run = 0, n_fail = 0;
  string cur_tag = "R1";
  bit rand_ready = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pktbuf_port #(.NUM_FRAMES(NF), .PKT_W(PW)) i_pktbuf_port (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_sel(req_sel), .req_off(req_off),
    .req_pkt(req_pkt), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  // behavioural reference model
  int       m_ptr;
  bit       m_vld;
  int       m_data;
  bit [7:0] m_mem [NF][2048];

  always @(posedge clk) begin
    if (rst) begin
      m_ptr = 0;
      m_vld = 0;
    end else begin
      bit rdy;
      rdy = !m_vld || rsp_ready;
      if (req_valid && rdy) begin
        int a;
        int v;
        bit okp;
        okp = int'(req_pkt) < NF;
        v = 0;
        if (req_sel == 2'd0) begin
          if (req_write) m_ptr = (m_ptr & 'hFF00) | int'(req_wdata);
          else v = m_ptr & 'hFF;
        end else if (req_sel == 2'd1) begin
          if (req_write) m_ptr = (m_ptr & 'h00FF) | (int'(req_wdata) << 8);
          else v = (m_ptr >> 8) & 'hFF;
        end else if (req_sel == 2'd2 && okp) begin
          if (m_ptr & 'h4000) begin
            a = m_ptr & 'h7FF;
            m_ptr = (m_ptr & 'hF800) | ((m_ptr + 1) & 'h7FF);
          end else begin
            a = ((m_ptr & 'h7FF) + int'(req_off)) & 'h7FF;
          end
          if (req_write) m_mem[req_pkt][a] = req_wdata;
          else v = int'(m_mem[req_pkt][a]);
        end
        if (!req_write) begin
          m_vld = 1;
          m_data = v;
        end else if (rsp_ready) m_vld = 0;
      end else if (rsp_ready) m_vld = 0;
    end
  end

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (!rst && !done) begin
      chk("R10", "req_ready", int'(req_ready), int'(!m_vld || rsp_ready));
      chk(cur_tag, "rsp_valid", int'(rsp_valid), int'(m_vld));
      if (m_vld) chk(cur_tag, "rsp_data", int'(rsp_data), m_data);
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rand_ready) rsp_ready = ($urandom_range(0, 2) != 0);
    end
  end

  task automatic issue(input logic w, input logic [1:0] sel, input logic [1:0] off,
                       input logic [PW-1:0] pkt, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_sel = sel;
    req_off = off; req_pkt = pkt; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [1:0] off,
                    input logic [PW-1:0] pkt, output int val);
    issue(1'b0, sel, off, pkt, 8'h00);
    #1;
    while (!rsp_valid) begin @(negedge clk); #1; end
    val = int'(rsp_data);
  endtask

  task automatic set_ptr(input logic [15:0] p);
    issue(1'b1, 2'd0, 2'd0, '0, p[7:0]);
    issue(1'b1, 2'd1, 2'd0, '0, p[15:8]);
  endtask

  task automatic chk_ptr(input string tag, input int exp);
    int lo, hi;
    rd(2'd0, 2'd0, '0, lo);
    rd(2'd1, 2'd0, '0, hi);
    chk(tag, "pointer", (hi << 8) | lo, exp);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);
    cur_tag = "R1";
    chk_ptr("R1", 'h0000);

    cur_tag = "R2";
    issue(1'b1, 2'd0, 2'd0, '0, 8'h34);
    chk_ptr("R2", 'h0034);
    issue(1'b1, 2'd1, 2'd0, '0, 8'h12);
    chk_ptr("R2", 'h1234);

    // fill both frames through autoincrement (R3, R9)
    cur_tag = "R9";
    for (int f = 0; f < NF; f++) begin
      set_ptr(16'h4000);
      for (int i = 0; i < 2048; i++)
        issue(1'b1, 2'd2, 2'(i), PW'(f), 8'((f * 37 + i * 7) & 255));
      chk_ptr("R4", 'h4000);
    end

    cur_tag = "R3";
    set_ptr(16'h4005);
    for (int k = 0; k < 4; k++) issue(1'b1, 2'd2, 2'd0, '0, 8'(8'hA0 + k));
    chk_ptr("R3", 'h4009);
    set_ptr(16'h0005);
    cur_tag = "R5";
    for (int k = 0; k < 4; k++) begin
      rd(2'd2, 2'(k), '0, v);
      chk("R5", "offset read", v, 'hA0 + k);
    end
    chk_ptr("R5", 'h0005);

    cur_tag = "R4";
    set_ptr(16'hCFFF);
    issue(1'b1, 2'd2, 2'd3, '0, 8'h5A);
    chk_ptr("R4", 'hC800);
    issue(1'b1, 2'd2, 2'd0, '0, 8'h77);
    chk_ptr("R4", 'hC801);

    cur_tag = "R6";
    set_ptr(16'h07FF);
    rd(2'd2, 2'd1, '0, v);  chk("R6", "wrap off1", v, 'h77);
    rd(2'd2, 2'd0, '0, v);  chk("R6", "top byte", v, 'h5A);
    chk_ptr("R6", 'h07FF);

    cur_tag = "R9";
    set_ptr(16'h0000);
    issue(1'b1, 2'd2, 2'd0, 1, 8'h99);
    rd(2'd2, 2'd0, 0, v);  chk("R9", "frame0 kept", v, 'h77);
    rd(2'd2, 2'd0, 1, v);  chk("R9", "frame1 written", v, 'h99);

    cur_tag = "R7";
    set_ptr(16'h4000);
    issue(1'b1, 2'd2, 2'd0, 2, 8'hEE);
    chk_ptr("R7", 'h4000);
    set_ptr(16'h0000);
    rd(2'd2, 2'd0, 0, v);  chk("R7", "frame0 untouched", v, 'h77);
    cur_tag = "R8";
    set_ptr(16'h4000);
    rd(2'd2, 2'd0, 3, v);  chk("R8", "invalid read", v, 0);
    chk_ptr("R8", 'h4000);

    cur_tag = "R11";
    issue(1'b1, 2'd3, 2'd0, '0, 8'hFF);
    chk_ptr("R11", 'h4000);
    rd(2'd3, 2'd0, '0, v); chk("R11", "unused select read", v, 0);

    cur_tag = "R10";
    set_ptr(16'h0000);
    @(negedge clk); rsp_ready = 1'b0;
    issue(1'b0, 2'd2, 2'd0, 1, 8'h00);
    repeat (3) @(negedge clk);
    #1;
    chk("R10", "held valid", int'(rsp_valid), 1);
    chk("R10", "held data", int'(rsp_data), 'h99);
    chk("R10", "stalled ready", int'(req_ready), 0);
    @(negedge clk); rsp_ready = 1'b1;
    @(negedge clk); #1;
    chk("R10", "released", int'(rsp_valid), 0);

    cur_tag = "R5";
    rand_ready = 1'b1;
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] s;
      s = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'd2;
      issue(1'($urandom_range(0, 1)), s, 2'($urandom_range(0, 3)),
            PW'($urandom_range(0, 3)), 8'($urandom_range(0, 255)));
    end
    rand_ready = 1'b0;
    @(negedge clk); rsp_ready = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1'b1;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule